// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a 12-bit voltage-output converter, rebuilt inside a system clock domain. A host drives a serial clock, a data line, an active-low frame strobe, an active-low load strobe, an active-low clear and a cascade-enable strap. All of these are brought into the system clock domain through two-flop synchronizers. Falling edges of the serial clock, the frame strobe and the load strobe are detected after synchronization. A 16-bit input shift register collects the word, and a 12-bit converter latch holds the code that the analog section would convert.

Two update modes are chosen per frame. The load strobe level is captured when the frame strobe falls. If it is low, the latch follows the register automatically on the 16th accepted clock edge. If it is high, the latch waits for a falling load strobe once a full word has arrived. With the cascade strap high, the edge limit is removed and the register's top bit is driven on a serial output, so that several converters can share one frame and one load strobe. The analog conversion and range selection lie outside this block.

Top module: `sdac_front`

## Requirements
- R1: After reset the converter code is 0 and the serial output is 0.
- R2: Data is sampled on each falling serial clock edge while the frame strobe is low, first bit into the top of the 16-bit register. The first 4 bits of a frame are dropped and the last 12 form the code, with the final bit as the code's LSB.
- R3: With the cascade strap low, only the first 16 falling edges of a frame shift the register; any further edges in that frame leave it unchanged.
- R4: If the load strobe is low when the frame strobe falls, the code updates on the 16th accepted edge with no load strobe activity.
- R5: If the load strobe is high when the frame strobe falls, the code does not change when the word completes, and updates on a later falling load strobe.
- R6: A falling load strobe before 16 edges of the current frame have been accepted leaves the code unchanged.
- R7: A frame ended before its 16th edge causes no automatic update, and the next frame counts from zero.
- R8: While the frame strobe is high, serial clock edges do not change the register.
- R9: A low clear forces the code to 0, taking priority over a load in the same cycle.
- R10: With the cascade strap high, every falling edge during the frame shifts the register and the serial output shows the register's top bit, so a bit leaves 16 edges after it entered.
- R11: With the cascade strap low, the serial output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; data taken on its falling edge |
| ser_din_i | input | 1 | Serial data in |
| frame_n_i | input | 1 | Active-low frame strobe |
| load_n_i | input | 1 | Active-low load strobe / mode select at frame start |
| clear_n_i | input | 1 | Active-low clear of the converter latch |
| chain_en_i | input | 1 | Cascade enable: removes the edge limit and enables serial out |
| dac_code_o | output | 12 | Converter latch contents |
| ser_dout_o | output | 1 | Serial data out for cascading |

## Verification
The assertions check every cycle that the edge counter never passes 16, and that the register holds while the frame strobe is high or once a non-cascaded frame has taken its 16 edges. They also check that a clear zeroes the code, that the code holds without a load event or on an early load strobe, and that the serial output stays low outside cascade mode. The choice of update mode at frame start, the drop of the leading nibble, the restart after a short frame and the 16-edge delay through the cascade path are shown only by the bench's scenarios, which compare the code and serial output with words worked out from the requirements.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic {
    UPD_EXTERNAL = 1'b0,
    UPD_AUTO     = 1'b1
  } upd_mode_e;

  // positions of the synchronized pins in the input bank
  localparam int unsigned PIN_SCLK  = 0;
  localparam int unsigned PIN_DIN   = 1;
  localparam int unsigned PIN_FRAME = 2;
  localparam int unsigned PIN_LOAD  = 3;
  localparam int unsigned PIN_CLEAR = 4;
  localparam int unsigned PIN_CHAIN = 5;
  localparam int unsigned PIN_COUNT = 6;

  // positions in the edge-detect bank
  localparam int unsigned EDG_SCLK  = 0;
  localparam int unsigned EDG_FRAME = 1;
  localparam int unsigned EDG_LOAD  = 2;
  localparam int unsigned EDG_COUNT = 3;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int unsigned N       = 6,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    always_ff @(posedge clk) begin
      if (rst) stage_q <= {STAGES{RST_VAL[g]}};
      else     stage_q <= {stage_q[STAGES-2:0], pin_i[g]};
    end
    assign level_o[g] = stage_q[STAGES-1];
  end
endmodule

// File: rtl/sdac_fall_detect.sv
module sdac_fall_detect #(
  parameter int unsigned N        = 3,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  input  logic              frame_active_i,
  input  logic              sclk_fall_i,
  input  logic              din_i,
  input  logic              chain_en_i,
  output logic [CODE_W-1:0] code_bits_o,
  output logic              msb_o,
  output logic              word_done_o,
  output logic              full_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_eff;
  logic              shift_en;
  logic              full_q;

  assign cnt_eff  = frame_start_i ? '0 : cnt_q;
  assign shift_en = frame_active_i && sclk_fall_i &&
                    (chain_en_i || (cnt_eff < CNT_FULL));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= shift_en && (cnt_eff == CNT_LAST);
      if (shift_en && (cnt_eff < CNT_FULL)) cnt_q <= cnt_eff + 1'b1;
      else                                  cnt_q <= cnt_eff;
      if (shift_en) sreg_q <= {sreg_q[WORD_W-2:0], din_i};
    end
  end

  assign code_bits_o  = sreg_q[CODE_W-1:0];
  assign msb_o        = sreg_q[WORD_W-1];
  assign word_done_o  = (cnt_q == CNT_FULL);
  assign full_pulse_o = full_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_active_i |=> $stable(sreg_q)); // R8
  AST_GATED_STOP: assert property (@(posedge clk) disable iff (rst)
    (!chain_en_i && word_done_o && !frame_start_i) |=> $stable(sreg_q)); // R3
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  input  logic              load_level_i,
  input  logic              load_fall_i,
  input  logic              clear_req_i,
  input  logic              full_pulse_i,
  input  logic              word_done_i,
  input  logic [CODE_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o
);
  upd_mode_e         mode_q;
  logic [CODE_W-1:0] code_q;
  logic              load_now;

  assign load_now = ((mode_q == UPD_AUTO) && full_pulse_i) ||
                    ((mode_q == UPD_EXTERNAL) && load_fall_i && word_done_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= UPD_EXTERNAL;
      code_q <= '0;
    end else begin
      if (frame_start_i) mode_q <= load_level_i ? UPD_EXTERNAL : UPD_AUTO;
      if (clear_req_i)   code_q <= '0;
      else if (load_now) code_q <= word_i;
    end
  end

  assign code_o = code_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear_req_i |=> (code_o == '0)); // R9
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!clear_req_i && !full_pulse_i && !load_fall_i) |=> $stable(code_o)); // R5
  AST_EARLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_fall_i && !word_done_i && !full_pulse_i && !clear_req_i) |=> $stable(code_o)); // R6
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  input  logic              frame_n_i,
  input  logic              load_n_i,
  input  logic              clear_n_i,
  input  logic              chain_en_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              ser_dout_o
);
  // idle values: clock high, data low, strobes high, cascade off
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 6'b011101;

  logic [PIN_COUNT-1:0] pins;
  logic [PIN_COUNT-1:0] lvl;
  logic [EDG_COUNT-1:0] edg_lvl;
  logic [EDG_COUNT-1:0] fall;
  logic [CODE_W-1:0]    code_bits;
  logic                 msb, word_done, full_pulse;
  logic                 sdo_q;

  always_comb begin
    pins            = '0;
    pins[PIN_SCLK]  = ser_clk_i;
    pins[PIN_DIN]   = ser_din_i;
    pins[PIN_FRAME] = frame_n_i;
    pins[PIN_LOAD]  = load_n_i;
    pins[PIN_CLEAR] = clear_n_i;
    pins[PIN_CHAIN] = chain_en_i;
  end

  sdac_pin_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pins), .level_o(lvl)
  );

  always_comb begin
    edg_lvl            = '0;
    edg_lvl[EDG_SCLK]  = lvl[PIN_SCLK];
    edg_lvl[EDG_FRAME] = lvl[PIN_FRAME];
    edg_lvl[EDG_LOAD]  = lvl[PIN_LOAD];
  end

  sdac_fall_detect #(.N(EDG_COUNT), .RST_VAL('1)) u_edge (
    .clk(clk), .rst(rst), .level_i(edg_lvl), .fall_o(fall)
  );

  sdac_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst(rst),
    .frame_start_i(fall[EDG_FRAME]),
    .frame_active_i(!lvl[PIN_FRAME]),
    .sclk_fall_i(fall[EDG_SCLK]),
    .din_i(lvl[PIN_DIN]),
    .chain_en_i(lvl[PIN_CHAIN]),
    .code_bits_o(code_bits),
    .msb_o(msb),
    .word_done_o(word_done),
    .full_pulse_o(full_pulse)
  );

  sdac_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst(rst),
    .frame_start_i(fall[EDG_FRAME]),
    .load_level_i(lvl[PIN_LOAD]),
    .load_fall_i(fall[EDG_LOAD]),
    .clear_req_i(!lvl[PIN_CLEAR]),
    .full_pulse_i(full_pulse),
    .word_done_i(word_done),
    .word_i(code_bits),
    .code_o(dac_code_o)
  );

  always_ff @(posedge clk) begin
    if (rst) sdo_q <= 1'b0;
    else     sdo_q <= lvl[PIN_CHAIN] ? msb : 1'b0;
  end

  assign ser_dout_o = sdo_q;

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lvl[PIN_CHAIN] |=> (ser_dout_o == 1'b0)); // R11
endmodule

// File: tb/sim_sdac_front.sv
`timescale 1ns/1ps
module sim_sdac_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, din = 1'b0, frame_n = 1'b1, load_n = 1'b1;
  logic        clear_n = 1'b1, chain_en = 1'b0;
  logic [11:0] code;
  logic        sdo;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  sdac_front u0 (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_din_i(din),
    .frame_n_i(frame_n), .load_n_i(load_n), .clear_n_i(clear_n),
    .chain_en_i(chain_en), .dac_code_o(code), .ser_dout_o(sdo)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    din = b;     cyc(3);
    sclk = 1'b0; cyc(6);
    sclk = 1'b1; cyc(3);
  endtask

  task automatic send(logic [15:0] w, int n);
    for (int i = 0; i < n; i++) bit_out(w[15-i]);
  endtask

  task automatic frame_begin;
    frame_n = 1'b0; cyc(6);
  endtask

  task automatic frame_end;
    frame_n = 1'b1; cyc(6);
  endtask

  task automatic load_pulse;
    load_n = 1'b0; cyc(6);
    load_n = 1'b1; cyc(6);
  endtask

  task automatic t_reset;
    chk("R1 code", {4'h0, code}, 16'h0000);
    chk("R1 sdo", {15'h0, sdo}, 16'h0000);
  endtask

  task automatic t_auto;
    load_n = 1'b0;
    frame_begin; send(16'hA5C3, 16); frame_end;
    chk("R4 R2 auto update", {4'h0, code}, 16'h05C3);
    frame_begin; send(16'hF000, 16); frame_end;
    chk("R2 leading nibble dropped", {4'h0, code}, 16'h0000);
    frame_begin; send(16'h0FFF, 16); frame_end;
    chk("R2 all-ones code", {4'h0, code}, 16'h0FFF);
    load_n = 1'b1; cyc(6);
  endtask

  task automatic t_external;
    frame_begin; send(16'h9234, 16);
    chk("R5 no update at word end", {4'h0, code}, 16'h0FFF);
    chk("R11 sdo low", {15'h0, sdo}, 16'h0000);
    frame_end; load_pulse;
    chk("R5 update on load strobe", {4'h0, code}, 16'h0234);
  endtask

  task automatic t_gating;
    frame_begin; send(16'h0ABC, 16); send(16'hFFFF, 4); frame_end;
    load_pulse;
    chk("R3 extra edges ignored", {4'h0, code}, 16'h0ABC);
  endtask

  task automatic t_early_load;
    frame_begin; send(16'h0777, 8);
    load_pulse;
    chk("R6 early load ignored", {4'h0, code}, 16'h0ABC);
    send(16'h7700, 8); frame_end; load_pulse;
    chk("R6 load after completion", {4'h0, code}, 16'h0777);
  endtask

  task automatic t_idle;
    send(16'hFFFF, 16);
    load_pulse;
    chk("R8 no shift while frame high", {4'h0, code}, 16'h0777);
  endtask

  task automatic t_short;
    load_n = 1'b0;
    frame_begin; send(16'h0111, 10); frame_end;
    chk("R7 short frame no update", {4'h0, code}, 16'h0777);
    frame_begin; send(16'h0222, 16); frame_end;
    chk("R7 count restarts", {4'h0, code}, 16'h0222);
    load_n = 1'b1; cyc(6);
  endtask

  task automatic t_clear;
    clear_n = 1'b0; cyc(6);
    chk("R9 clear", {4'h0, code}, 16'h0000);
    clear_n = 1'b1; cyc(6);
    frame_begin; send(16'h0999, 16); frame_end;
    load_n = 1'b0; clear_n = 1'b0; cyc(6);
    load_n = 1'b1; clear_n = 1'b1; cyc(6);
    chk("R9 clear beats load", {4'h0, code}, 16'h0000);
  endtask

  task automatic t_chain;
    logic [15:0] a = 16'hC3A5;
    logic [15:0] b = 16'h0E81;
    chain_en = 1'b1; cyc(6);
    frame_begin; send(a, 16);
    chk("R10 sdo after first word", {15'h0, sdo}, {15'h0, a[15]});
    for (int k = 0; k < 16; k++) begin
      chk("R10 sdo stream", {15'h0, sdo}, {15'h0, a[15-k]});
      bit_out(b[15-k]);
    end
    frame_end; load_pulse;
    chk("R10 second word latched", {4'h0, code}, {4'h0, b[11:0]});
    chain_en = 1'b0; cyc(6);
    chk("R11 sdo low after cascade off", {15'h0, sdo}, 16'h0000);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(6);
    t_reset;
    t_auto;
    t_external;
    t_gating;
    t_early_load;
    t_idle;
    t_short;
    t_clear;
    t_chain;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule